// File: doc/BRIEF.md
# Sequential Four-Stage Sample Trigger

This block watches a stream of 32-bit logic samples and decides when a capture begins and when it ends. It holds a small bank of trigger stages. Each stage carries a compare mask, a compare value and a start flag. After an arm pulse the block looks only at the current stage. A match on a stage whose start flag is clear moves the sequence on to the next stage. A match on a stage whose start flag is set fires the trigger. Because each stage consumes its own sample, a sequence of N stages needs at least N samples to complete.

From the arm pulse onward, every valid sample raises a write enable toward an external circular sample memory, so the history before the trigger is kept. Once the trigger fires, a post-trigger counter allows a programmed number of further samples and then raises done. Done stays high until the next arm pulse. The command decoder loads the stage registers and the capture sizes through a simple write port.

Top module: `stage_trigger_core`

## Requirements
- R1: After reset, active_o, trig_o, done_o and mem_we_o are all 0.
- R2: A stage matches a sample when, for every bit set in its mask, the sample bit equals the value bit. Bits whose mask bit is clear are ignored, so a mask of 0 matches any sample.
- R3: A match on the current stage fires the trigger when that stage's start flag (configuration word bit 3, value 0x08) is set. trig_o is high from the cycle after that sample and stays high until the next arm. A match on a stage whose start flag is clear moves to the next stage instead.
- R4: Stages are examined strictly in order from stage 0. A sample that matches only a later stage has no effect.
- R5: Each valid sample advances the sequence by at most one stage. A sample that matches both the current stage and the next one moves only one step.
- R6: With stage 0 programmed with mask 0 and its start flag set, the first valid sample after arm fires the trigger.
- R7: After the triggering sample, exactly L+1 further valid samples are written, where L = min(delay, read) and the sizes word holds read in bits [31:16] and delay in bits [15:0]. done_o rises in the cycle after the last of these samples, active_o falls with it, and mem_we_o stays 0 from then on.
- R8: While active_o is high, mem_we_o equals smp_vld_i (the triggering sample included). mem_we_o is 0 whenever active_o is low.
- R9: An arm pulse clears the stage index, the post counter, trig_o and done_o, and sets active_o in the next cycle. done_o, once high, holds until that pulse.
- R10: A write with cfg_we_i high selects a register with cfg_sel_i: 0 loads the mask of stage cfg_stage_i, 1 its value, 2 its configuration word, and 3 the shared sizes word.
- R11: Cycles in which smp_vld_i is low neither advance the stage sequence nor count post-trigger samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_i | input | 32 | Input sample |
| smp_vld_i | input | 1 | Sample valid strobe |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 mask, 1 value, 2 config, 3 sizes |
| cfg_stage_i | input | 2 | Stage addressed by the write |
| cfg_data_i | input | 32 | Write data |
| arm_i | input | 1 | Start-of-run pulse |
| active_o | output | 1 | Run in progress |
| trig_o | output | 1 | Trigger has fired in this run |
| mem_we_o | output | 1 | Sample memory write enable |
| done_o | output | 1 | Post-trigger capture complete |

## Verification
The bench presents a sample that matches a later stage before the earlier stage has matched. A design that evaluated all stages in parallel would trigger early on it. One sample satisfies two consecutive stages at once, and a design that skipped ahead on it would trigger a sample too soon. Masked bits are mismatched on purpose, and a valid strobe is held low over a matching sample, so that a comparator or a counter that ignored either would fire. The post-trigger count is checked with a delay larger than the read size and with a pause in the valid strobe: an off-by-one or a missing clamp shows up as an extra or missing write enable or as done rising one sample late. A re-arm in the middle of a run must drop the sequence back to stage 0.

// File: rtl/stg_trig_pkg.sv
package stg_trig_pkg;
  typedef enum logic [1:0] {
    SEL_MASK   = 2'd0,
    SEL_VALUE  = 2'd1,
    SEL_CONFIG = 2'd2,
    SEL_SIZES  = 2'd3
  } cfg_sel_e;

  localparam int START_FLAG_BIT = 3;
endpackage

// File: rtl/stg_cfg_regs.sv
module stg_cfg_regs
  import stg_trig_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_STAGES = 4,
  parameter int CNT_W      = 16,
  parameter int IDX_W      = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we_i,
  input  logic [1:0]                       sel_i,
  input  logic [IDX_W-1:0]                 stage_i,
  input  logic [DATA_W-1:0]                data_i,
  output logic [NUM_STAGES-1:0][DATA_W-1:0] mask_o,
  output logic [NUM_STAGES-1:0][DATA_W-1:0] value_o,
  output logic [NUM_STAGES-1:0]            start_o,
  output logic [CNT_W-1:0]                 limit_o
);
  logic [CNT_W-1:0] read_q, delay_q;
  logic             sizes_en;

  assign sizes_en = we_i && (cfg_sel_e'(sel_i) == SEL_SIZES);

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    logic hit_stage;
    logic mask_en, value_en, cfg_en;
    assign hit_stage = we_i && (stage_i == IDX_W'(s));
    assign mask_en   = hit_stage && (cfg_sel_e'(sel_i) == SEL_MASK);
    assign value_en  = hit_stage && (cfg_sel_e'(sel_i) == SEL_VALUE);
    assign cfg_en    = hit_stage && (cfg_sel_e'(sel_i) == SEL_CONFIG);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_o[s]  <= '0;
        value_o[s] <= '0;
        start_o[s] <= 1'b0;
      end else begin
        if (mask_en)  mask_o[s]  <= data_i;
        if (value_en) value_o[s] <= data_i;
        if (cfg_en)   start_o[s] <= data_i[START_FLAG_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      read_q  <= '0;
      delay_q <= '0;
    end else if (sizes_en) begin
      read_q  <= data_i[2*CNT_W-1:CNT_W];
      delay_q <= data_i[CNT_W-1:0];
    end
  end

  assign limit_o = (delay_q > read_q) ? read_q : delay_q;
endmodule

// File: rtl/stg_match.sv
module stg_match #(
  parameter int DATA_W     = 32,
  parameter int NUM_STAGES = 4
) (
  input  logic [DATA_W-1:0]                 smp_i,
  input  logic [NUM_STAGES-1:0][DATA_W-1:0] mask_i,
  input  logic [NUM_STAGES-1:0][DATA_W-1:0] value_i,
  output logic [NUM_STAGES-1:0]             hit_o
);
  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_cmp
    assign hit_o[s] = ~|((smp_i ^ value_i[s]) & mask_i[s]);
  end
endmodule

// File: rtl/stg_sequencer.sv
module stg_sequencer #(
  parameter int NUM_STAGES = 4,
  parameter int IDX_W      = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  arm_i,
  input  logic                  step_i,
  input  logic [NUM_STAGES-1:0] hit_i,
  input  logic [NUM_STAGES-1:0] start_i,
  output logic                  trig_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_STAGES - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             trig_q, trig_d;
  logic             cur_hit, cur_start;

  assign cur_hit   = hit_i[idx_q];
  assign cur_start = start_i[idx_q];

  always_comb begin
    idx_d  = idx_q;
    trig_d = trig_q;
    if (arm_i) begin
      idx_d  = '0;
      trig_d = 1'b0;
    end else if (step_i && !trig_q && cur_hit) begin
      if (cur_start) trig_d = 1'b1;
      else if (idx_q != LAST_IDX) idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      trig_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      trig_q <= trig_d;
    end
  end

  assign trig_o = trig_q;
endmodule

// File: rtl/stg_post_cnt.sv
module stg_post_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             trig_i,
  input  logic             vld_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             active_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             active_q, active_d;
  logic             done_q, done_d;
  logic             count_en;

  assign count_en = active_q && trig_i && vld_i;

  always_comb begin
    cnt_d    = cnt_q;
    active_d = active_q;
    done_d   = done_q;
    if (arm_i) begin
      cnt_d    = '0;
      active_d = 1'b1;
      done_d   = 1'b0;
    end else if (count_en) begin
      if (cnt_q == limit_i) begin
        active_d = 1'b0;
        done_d   = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      active_q <= active_d;
      done_q   <= done_d;
    end
  end

  assign active_o = active_q;
  assign done_o   = done_q;
endmodule

// File: rtl/stage_trigger_core.sv
module stage_trigger_core #(
  parameter int DATA_W     = 32,
  parameter int NUM_STAGES = 4,
  parameter int CNT_W      = 16,
  localparam int IDX_W     = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] smp_i,
  input  logic              smp_vld_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [IDX_W-1:0]  cfg_stage_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  input  logic              arm_i,
  output logic              active_o,
  output logic              trig_o,
  output logic              mem_we_o,
  output logic              done_o
);
  logic [NUM_STAGES-1:0][DATA_W-1:0] mask_w, value_w;
  logic [NUM_STAGES-1:0]             start_w, hit_w;
  logic [CNT_W-1:0]                  limit_w;
  logic                              active_w, trig_w, step_w;

  stg_cfg_regs #(
    .DATA_W(DATA_W), .NUM_STAGES(NUM_STAGES), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .sel_i(cfg_sel_i),
    .stage_i(cfg_stage_i), .data_i(cfg_data_i),
    .mask_o(mask_w), .value_o(value_w), .start_o(start_w), .limit_o(limit_w)
  );

  stg_match #(.DATA_W(DATA_W), .NUM_STAGES(NUM_STAGES)) u_match (
    .smp_i(smp_i), .mask_i(mask_w), .value_i(value_w), .hit_o(hit_w)
  );

  assign step_w = active_w && smp_vld_i;

  stg_sequencer #(.NUM_STAGES(NUM_STAGES), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .step_i(step_w),
    .hit_i(hit_w), .start_i(start_w), .trig_o(trig_w)
  );

  stg_post_cnt #(.CNT_W(CNT_W)) u_post (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .trig_i(trig_w),
    .vld_i(smp_vld_i), .limit_i(limit_w),
    .active_o(active_w), .done_o(done_o)
  );

  assign active_o = active_w;
  assign trig_o   = trig_w;
  assign mem_we_o = active_w && smp_vld_i && !arm_i;
endmodule

// File: rtl/stage_trigger_chk.sv
module stage_trigger_chk (
  input logic clk,
  input logic rst_n,
  input logic smp_vld_i,
  input logic arm_i,
  input logic active_o,
  input logic trig_o,
  input logic mem_we_o,
  input logic done_o
);
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !arm_i |=> done_o); // R9
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> active_o && !done_o && !trig_o); // R9
  AST_NO_WE_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_we_o); // R7
  AST_DONE_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(trig_o) && $past(smp_vld_i)); // R7
  AST_WE_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> smp_vld_i && active_o); // R8
  AST_TRIG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o && !arm_i |=> trig_o); // R3
  AST_TRIG_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_o) |-> $past(smp_vld_i) && $past(active_o)); // R11
endmodule

bind stage_trigger_core stage_trigger_chk u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld_i(smp_vld_i), .arm_i(arm_i),
  .active_o(active_o), .trig_o(trig_o), .mem_we_o(mem_we_o), .done_o(done_o)
);

// File: tb/stage_trigger_core_tb_top.sv
`timescale 1ns/1ps
module stage_trigger_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] smp = '0;
  logic        vld = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [1:0]  cfg_stage = '0;
  logic [31:0] cfg_data = '0;
  logic        arm = 1'b0;
  logic        active, trig, we, done;
  logic        we_seen;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  stage_trigger_core dut_i (
    .clk(clk), .rst_n(rst_n), .smp_i(smp), .smp_vld_i(vld),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_stage_i(cfg_stage),
    .cfg_data_i(cfg_data), .arm_i(arm),
    .active_o(active), .trig_o(trig), .mem_we_o(we), .done_o(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [1:0] stg, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_stage = stg; cfg_data = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic do_arm();
    @(negedge clk);
    arm = 1'b1; vld = 1'b0;
    @(posedge clk); #1;
    arm = 1'b0;
  endtask

  // drive one cycle; we_seen holds mem_we for that cycle, trig/done read after the edge
  task automatic drive(input logic [31:0] s, input logic v);
    @(negedge clk);
    smp = s; vld = v;
    #1 we_seen = we;
    @(posedge clk); #1;
    vld = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 active", active, 0);
    chk("R1 trig", trig, 0);
    chk("R1 done", done, 0);
    chk("R1 mem_we", we, 0);
  endtask

  // stage 0 always-start, read 7 delay 2 -> L=2, three post samples
  task automatic t_immediate();
    wr(2'd0, 2'd0, 32'h0);
    wr(2'd2, 2'd0, 32'h8);
    wr(2'd3, 2'd0, {16'd7, 16'd2});
    do_arm();
    chk("R9 active after arm", active, 1);
    drive(32'hDEADBEEF, 1);
    chk("R8 we on trigger sample", we_seen, 1);
    chk("R6 trig on first sample", trig, 1);
    drive(32'h1, 1);
    chk("R7 post1 we", we_seen, 1);
    chk("R7 not done post1", done, 0);
    drive(32'h2, 0);
    chk("R8 no we without valid", we_seen, 0);
    chk("R11 invalid not counted", done, 0);
    drive(32'h3, 1);
    chk("R7 post2 we", we_seen, 1);
    chk("R7 not done post2", done, 0);
    drive(32'h4, 1);
    chk("R7 post3 we", we_seen, 1);
    chk("R7 done after L+1", done, 1);
    chk("R7 active drops", active, 0);
    drive(32'h5, 1);
    chk("R7 no we after done", we_seen, 0);
    drive(32'h6, 0);
    drive(32'h7, 0);
    chk("R9 done holds", done, 1);
  endtask

  // R10 encodings: sel 0 mask, 1 value, 2 config (bit 3 = start), 3 sizes
  task automatic cfg_two_stage();
    wr(2'd0, 2'd0, 32'h0000FF00);
    wr(2'd1, 2'd0, 32'h00003400);
    wr(2'd2, 2'd0, 32'h0);
    wr(2'd0, 2'd1, 32'h0000000F);
    wr(2'd1, 2'd1, 32'h00000005);
    wr(2'd2, 2'd1, 32'h8);
    wr(2'd3, 2'd0, {16'd3, 16'd0});
  endtask

  task automatic t_sequence();
    cfg_two_stage();
    do_arm();
    chk("R9 trig cleared by arm", trig, 0);
    chk("R9 done cleared by arm", done, 0);
    drive(32'h00000005, 1);
    chk("R4 later stage alone ignored", trig, 0);
    drive(32'h12343405, 0);
    chk("R11 invalid sample no advance", trig, 0);
    drive(32'h00000005, 1);
    chk("R11 still at stage 0", trig, 0);
    drive(32'h00003505, 1);
    chk("R2 masked bit mismatch", trig, 0);
    drive(32'hFFFF34F5, 1);
    chk("R5 double match advances once", trig, 0);
    drive(32'hABCD0005, 1);
    chk("R3 start stage fires", trig, 1);
    chk("R10 sizes L=0 not done yet", done, 0);
    drive(32'h0, 1);
    chk("R7 single post sample we", we_seen, 1);
    chk("R7 done after one post", done, 1);
  endtask

  task automatic t_rearm_midrun();
    do_arm();
    drive(32'h00003400, 1);
    chk("R3 stage0 no start no trig", trig, 0);
    do_arm();
    drive(32'h00000005, 1);
    chk("R9 arm resets stage index", trig, 0);
    drive(32'h00003400, 1);
    drive(32'h00000005, 1);
    chk("R3 fires after full sequence", trig, 1);
  endtask

  // delay 5 > read 1 -> L=1, two post samples
  task automatic t_clamp();
    wr(2'd0, 2'd0, 32'h0);
    wr(2'd2, 2'd0, 32'h8);
    wr(2'd3, 2'd0, {16'd1, 16'd5});
    do_arm();
    drive(32'h0, 1);
    chk("R6 trig", trig, 1);
    drive(32'h0, 1);
    chk("R7 clamp post1", done, 0);
    drive(32'h0, 1);
    chk("R7 clamp done after two", done, 1);
    drive(32'h0, 1);
    chk("R8 we low after run", we_seen, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_immediate();
    t_sequence();
    t_rearm_midrun();
    t_clamp();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule